// File: doc/BRIEF.md
# Selectable-Width Bus Matching Port

This block sits between an 80-bit internal FIFO word path and two external ports. Each external port can be 80, 40, 20 or 10 bits wide, and a pair of size inputs on each port picks the width. On the write side, a packer gathers one, two, four or eight narrow enabled transfers into one internal word and hands that word to the FIFO over a ready/valid handshake. On the read side, a splitter takes one internal word from the FIFO and presents it as one, two, four or eight narrow slices. Each enabled read moves to the next slice.

The slice order on the read side comes from an endianness mode that is sampled while master reset is held. In little-endian mode the lowest slice goes out first. In big-endian mode the highest slice goes out first. The write side always fills from the lowest slice upward. Each side latches its width at the start of a word, so a change on the size inputs part-way through a word does not take effect until the next word.

The packer is a two-state machine. W_FILL accepts slices. W_HOLD presents a finished word to the FIFO. The W_FILL to W_HOLD transition happens on acceptance of the last slice. The W_HOLD to W_FILL transition happens when the FIFO takes the word and no new word completes in the same cycle; otherwise the machine stays in W_HOLD. The splitter is also a two-state machine. R_IDLE holds no word and requests one. R_SEND presents slices. R_IDLE moves to R_SEND when a word is loaded. R_SEND returns to R_IDLE when the last slice is read and no new word arrives in the same cycle; otherwise it stays in R_SEND with the new word.

Top module: `bus_match_port`

## Requirements
- R1: One cycle after master reset, rd_valid and fifo_wvalid are 0 while wr_ready and fifo_rready are 1. The read order is taken from be_sel only while master reset is high, so later changes of be_sel have no effect.
- R2: The size code sets the port width and the number of transfers per internal word: 00 is 80 bits (1 transfer), 01 is 40 bits (2), 10 is 20 bits (4) and 11 is 10 bits (8).
- R3: On the write side, the k-th accepted transfer of a word (k counted from 0) lands in internal bits [k*w +: w], where w is the port width. wr_data bits at and above w are ignored.
- R4: After its last slice is accepted, a completed write word appears on fifo_wdata with fifo_wvalid high in the next cycle. It stays there, unchanged, until a cycle in which fifo_wready is high.
- R5: wr_ready is low only while a completed word is waiting and fifo_wready is low.
- R6: On the read side with be_sel 0 at reset, the k-th slice is internal bits [k*w +: w]. With be_sel 1, the k-th slice is bits [(n-1-k)*w +: w], where n is the number of slices.
- R7: rd_data bits at and above the current port width are 0.
- R8: The read slice advances only on a cycle in which rd_en and rd_valid are both high; otherwise rd_data and rd_valid hold.
- R9: fifo_rready is high only when no word is held, or when rd_en is high on the last slice. In the second case a waiting word is taken in the same cycle, so no empty cycle falls between words.
- R10: A change of wr_size or rd_size after the first slice of a word has no effect on that word. Each side uses the size that was present when the word started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst | input | 1 | Synchronous master reset, active high |
| be_sel | input | 1 | Read order, sampled during master reset: 1 = most significant slice first |
| wr_size | input | 2 | Write port size code |
| wr_en | input | 1 | Write transfer enable |
| wr_data | input | 80 | Write port data, low bits used |
| wr_ready | output | 1 | Write port can accept a transfer |
| fifo_wdata | output | 80 | Packed word to the FIFO |
| fifo_wvalid | output | 1 | Packed word is valid |
| fifo_wready | input | 1 | FIFO accepts the packed word |
| rd_size | input | 2 | Read port size code |
| rd_en | input | 1 | Read transfer enable |
| rd_data | output | 80 | Read port slice, upper bits zero |
| rd_valid | output | 1 | A slice is present on rd_data |
| fifo_rdata | input | 80 | Word from the FIFO |
| fifo_rvalid | input | 1 | FIFO word is valid |
| fifo_rready | output | 1 | Splitter takes the FIFO word |

## Verification
A slice counter that is off by one shows up at once: the next rd_data slice is wrong, or fifo_rready rises one transfer too early or too late. Either symptom appears in the same cycle as the faulty count. An error in the latched endianness or size reverses or re-widths every slice of the next word, so it is visible from that word's first read transfer. A fault in the packer shows on fifo_wdata in the first cycle of W_HOLD. A fault in the stall logic shows as wr_ready or fifo_wvalid changing while fifo_wready is held low.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [0:0] {
        W_FILL = 1'b0,
        W_HOLD = 1'b1
    } wr_state_t;

    typedef enum logic [0:0] {
        R_IDLE = 1'b0,
        R_SEND = 1'b1
    } rd_state_t;

endpackage

// File: rtl/bm_mode_latch.sv
module bm_mode_latch (
    input  logic clk,
    input  logic mrst,
    input  logic be_sel,
    output logic big_endian
);
    logic be_q;

    always_ff @(posedge clk) begin
        if (mrst) be_q <= be_sel;
    end

    assign big_endian = be_q;
endmodule

// File: rtl/bm_pack.sv
module bm_pack
    import bm_pkg::*;
#(
    parameter int UNIT_W  = 10,
    parameter int LOG_MAX = 3,
    localparam int UNITS  = 1 << LOG_MAX,
    localparam int WORD_W = UNIT_W * UNITS,
    localparam int SIZE_W = $clog2(LOG_MAX + 1),
    localparam int CNT_W  = LOG_MAX
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic [SIZE_W-1:0] size_in,
    input  logic              ext_en,
    input  logic [WORD_W-1:0] ext_data,
    output logic              ext_ready,
    output logic [WORD_W-1:0] fifo_data,
    output logic              fifo_valid,
    input  logic              fifo_ready
);
    wr_state_t state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] eff_size;
    logic [CNT_W-1:0]  slices_m1;
    logic              last;
    logic              accept;
    logic [UNITS-1:0][UNIT_W-1:0] word_q;
    logic [UNITS-1:0][UNIT_W-1:0] ext_units;

    assign ext_units = ext_data;
    assign eff_size  = (cnt_q == '0) ? size_in : size_q;
    assign slices_m1 = CNT_W'((32'd1 << eff_size) - 32'd1);
    assign last      = (cnt_q == slices_m1);
    assign accept    = ext_en && ext_ready;

    // state register
    always_ff @(posedge clk) begin
        if (mrst) state_q <= W_FILL;
        else      state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_FILL: if (accept && last) state_d = W_HOLD;
            W_HOLD: if (fifo_ready && !(accept && last)) state_d = W_FILL;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            W_FILL: begin
                ext_ready  = 1'b1;
                fifo_valid = 1'b0;
            end
            W_HOLD: begin
                ext_ready  = fifo_ready;
                fifo_valid = 1'b1;
            end
        endcase
    end

    // slice counter and width latch
    always_ff @(posedge clk) begin
        if (mrst) begin
            cnt_q  <= '0;
            size_q <= '0;
        end else if (accept) begin
            if (cnt_q == '0) size_q <= size_in;
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // per-unit placement of the incoming slice
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        logic             hit;
        logic [CNT_W-1:0] src;
        always_comb begin
            hit = (CNT_W'(u >> (LOG_MAX - int'(eff_size))) == cnt_q);
            src = CNT_W'(u & ((1 << (LOG_MAX - int'(eff_size))) - 1));
        end
        always_ff @(posedge clk) begin
            if (mrst)              word_q[u] <= '0;
            else if (accept && hit) word_q[u] <= ext_units[src];
        end
    end

    assign fifo_data = word_q;
endmodule

// File: rtl/bm_split.sv
module bm_split
    import bm_pkg::*;
#(
    parameter int UNIT_W  = 10,
    parameter int LOG_MAX = 3,
    localparam int UNITS  = 1 << LOG_MAX,
    localparam int WORD_W = UNIT_W * UNITS,
    localparam int SIZE_W = $clog2(LOG_MAX + 1),
    localparam int CNT_W  = LOG_MAX
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              big_endian,
    input  logic [SIZE_W-1:0] size_in,
    input  logic              ext_en,
    output logic [WORD_W-1:0] ext_data,
    output logic              ext_valid,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_valid,
    output logic              fifo_ready
);
    rd_state_t state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SIZE_W-1:0] size_q;
    logic [CNT_W-1:0]  slices_m1;
    logic [CNT_W-1:0]  phys;
    logic              last;
    logic              take;
    logic              load;
    logic [UNITS-1:0][UNIT_W-1:0] word_q;
    logic [UNITS-1:0][UNIT_W-1:0] out_units;

    assign slices_m1 = CNT_W'((32'd1 << size_q) - 32'd1);
    assign last      = (cnt_q == slices_m1);
    assign take      = ext_en && ext_valid;
    assign load      = fifo_ready && fifo_valid;
    assign phys      = big_endian ? (slices_m1 - cnt_q) : cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (mrst) state_q <= R_IDLE;
        else      state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE: if (load) state_d = R_SEND;
            R_SEND: if (take && last && !load) state_d = R_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            R_IDLE: begin
                ext_valid  = 1'b0;
                fifo_ready = 1'b1;
            end
            R_SEND: begin
                ext_valid  = 1'b1;
                fifo_ready = ext_en && last;
            end
        endcase
    end

    // word, width and slice counter
    always_ff @(posedge clk) begin
        if (mrst) begin
            word_q <= '0;
            size_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            word_q <= fifo_data;
            size_q <= size_in;
            cnt_q  <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // slice selection onto the low units, zero above
    for (genvar j = 0; j < UNITS; j++) begin : g_out
        int               per;
        logic [CNT_W-1:0] idx;
        always_comb begin
            per = 1 << (LOG_MAX - int'(size_q));
            idx = CNT_W'((int'(phys) << (LOG_MAX - int'(size_q))) + j);
            out_units[j] = (j < per) ? word_q[idx] : '0;
        end
    end

    assign ext_data = out_units;
endmodule

// File: rtl/bus_match_port.sv
module bus_match_port #(
    parameter int UNIT_W  = 10,
    parameter int LOG_MAX = 3,
    localparam int WORD_W = UNIT_W << LOG_MAX,
    localparam int SIZE_W = $clog2(LOG_MAX + 1)
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              be_sel,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic [WORD_W-1:0] fifo_wdata,
    output logic              fifo_wvalid,
    input  logic              fifo_wready,
    input  logic [SIZE_W-1:0] rd_size,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [WORD_W-1:0] fifo_rdata,
    input  logic              fifo_rvalid,
    output logic              fifo_rready
);
    logic big_endian;

    bm_mode_latch u_mode (
        .clk        (clk),
        .mrst       (mrst),
        .be_sel     (be_sel),
        .big_endian (big_endian)
    );

    bm_pack #(.UNIT_W(UNIT_W), .LOG_MAX(LOG_MAX)) u_pack (
        .clk        (clk),
        .mrst       (mrst),
        .size_in    (wr_size),
        .ext_en     (wr_en),
        .ext_data   (wr_data),
        .ext_ready  (wr_ready),
        .fifo_data  (fifo_wdata),
        .fifo_valid (fifo_wvalid),
        .fifo_ready (fifo_wready)
    );

    bm_split #(.UNIT_W(UNIT_W), .LOG_MAX(LOG_MAX)) u_split (
        .clk        (clk),
        .mrst       (mrst),
        .big_endian (big_endian),
        .size_in    (rd_size),
        .ext_en     (rd_en),
        .ext_data   (rd_data),
        .ext_valid  (rd_valid),
        .fifo_data  (fifo_rdata),
        .fifo_valid (fifo_rvalid),
        .fifo_ready (fifo_rready)
    );
endmodule

// File: rtl/bm_port_chk.sv
module bm_port_chk #(
    parameter int UNIT_W  = 10,
    parameter int LOG_MAX = 3,
    localparam int WORD_W = UNIT_W << LOG_MAX
) (
    input logic              clk,
    input logic              mrst,
    input logic              wr_en,
    input logic              wr_ready,
    input logic [WORD_W-1:0] fifo_wdata,
    input logic              fifo_wvalid,
    input logic              fifo_wready,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              fifo_rready
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        mrst |=> (!rd_valid && !fifo_wvalid && wr_ready));

    assert_word_after_transfer_R2: assert property (@(posedge clk) disable iff (mrst)
        $rose(fifo_wvalid) |-> $past(wr_en && wr_ready));

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (mrst)
        (fifo_wvalid && !fifo_wready) |=> (fifo_wvalid && $stable(fifo_wdata)));

    assert_wr_stall_R5: assert property (@(posedge clk) disable iff (mrst)
        !wr_ready |-> (fifo_wvalid && !fifo_wready));

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (mrst)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

    assert_rd_request_R9: assert property (@(posedge clk) disable iff (mrst)
        (rd_valid && !rd_en) |-> !fifo_rready);
endmodule

bind bus_match_port bm_port_chk #(.UNIT_W(UNIT_W), .LOG_MAX(LOG_MAX)) u_chk (
    .clk         (clk),
    .mrst        (mrst),
    .wr_en       (wr_en),
    .wr_ready    (wr_ready),
    .fifo_wdata  (fifo_wdata),
    .fifo_wvalid (fifo_wvalid),
    .fifo_wready (fifo_wready),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .fifo_rready (fifo_rready)
);

// File: tb/bus_match_port_test.sv
module bus_match_port_test;
    localparam int PERIOD = 10;
    localparam int WW     = 80;

    logic          clk = 1'b0;
    logic          mrst, be_sel, wr_en, fifo_wready, rd_en, fifo_rvalid;
    logic [1:0]    wr_size, rd_size;
    logic [WW-1:0] wr_data, fifo_rdata;
    logic          wr_ready, fifo_wvalid, rd_valid, fifo_rready;
    logic [WW-1:0] fifo_wdata, rd_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bus_match_port uut (
        .clk(clk), .mrst(mrst), .be_sel(be_sel),
        .wr_size(wr_size), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .fifo_wdata(fifo_wdata), .fifo_wvalid(fifo_wvalid), .fifo_wready(fifo_wready),
        .rd_size(rd_size), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .fifo_rdata(fifo_rdata), .fifo_rvalid(fifo_rvalid), .fifo_rready(fifo_rready)
    );

    task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                         input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [WW-1:0] slice_of(input logic [WW-1:0] word, input int size,
                                               input bit be, input int k);
        int          w = WW >> size;
        int          n = 1 << size;
        int          p = be ? (n - 1 - k) : k;
        logic [WW:0] m = ({{WW{1'b0}}, 1'b1} << w) - 1;
        return (word >> (p * w)) & m[WW-1:0];
    endfunction

    task automatic do_reset(input bit be);
        @(negedge clk);
        mrst = 1'b1; be_sel = be;
        wr_en = 0; wr_size = 0; wr_data = 0; fifo_wready = 0;
        rd_en = 0; rd_size = 0; fifo_rdata = 0; fifo_rvalid = 0;
        repeat (2) @(negedge clk);
        mrst = 1'b0;
        #1;
        check(rd_valid == 0,    "R1 rd_valid", WW'(rd_valid), 0);
        check(fifo_wvalid == 0, "R1 fifo_wvalid", WW'(fifo_wvalid), 0);
        check(wr_ready == 1,    "R1 wr_ready", WW'(wr_ready), 1);
        check(fifo_rready == 1, "R1 fifo_rready", WW'(fifo_rready), 1);
        be_sel = ~be; // R1: no effect outside reset
    endtask

    // R2 R6 R7 R8 R9 R10: split one word
    task automatic rd_word(input int size, input bit be, input logic [WW-1:0] word);
        int n = 1 << size;
        @(negedge clk);
        fifo_rvalid = 1; fifo_rdata = word; rd_size = 2'(size); rd_en = 0;
        #1 check(fifo_rready == 1, "R9 idle request", WW'(fifo_rready), 1);
        @(negedge clk);
        fifo_rvalid = 0; fifo_rdata = '0; rd_size = ~2'(size); // R10
        #1;
        check(rd_valid == 1, "R8 valid before enable", WW'(rd_valid), 1);
        check(rd_data == slice_of(word, size, be, 0), "R8 R6 stall slice",
              rd_data, slice_of(word, size, be, 0));
        check(fifo_rready == 0, "R9 no request while held", WW'(fifo_rready), 0);
        for (int k = 0; k < n; k++) begin
            rd_en = 1;
            #1;
            check(rd_data == slice_of(word, size, be, k), "R6 R7 R10 slice",
                  rd_data, slice_of(word, size, be, k));
            check(fifo_rready == (k == n - 1), "R9 request at last",
                  WW'(fifo_rready), WW'(k == n - 1));
            @(negedge clk);
        end
        rd_en = 0;
        #1 check(rd_valid == 0, "R2 slice count", WW'(rd_valid), 0);
    endtask

    // R2 R3 R4 R5 R10: pack one word
    task automatic wr_word(input int size, input logic [WW-1:0] word);
        int          n = 1 << size;
        int          w = WW >> size;
        logic [WW-1:0] junk = {WW{1'b1}} << w;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1; fifo_wready = 0;
            wr_size = (k == 0) ? 2'(size) : ~2'(size); // R10
            wr_data = slice_of(word, size, 1'b0, k) | junk;
            #1 check(wr_ready == 1, "R5 ready while filling", WW'(wr_ready), 1);
        end
        @(negedge clk);
        wr_en = 0; wr_data = 0;
        #1;
        check(fifo_wvalid == 1, "R4 word valid", WW'(fifo_wvalid), 1);
        check(fifo_wdata == word, "R3 R10 packed word", fifo_wdata, word);
        check(wr_ready == 0, "R5 stall", WW'(wr_ready), 0);
        @(negedge clk);
        #1 check(fifo_wdata == word && fifo_wvalid, "R4 held", fifo_wdata, word);
        fifo_wready = 1;
        #1 check(wr_ready == 1, "R5 ready with fifo ready", WW'(wr_ready), 1);
        @(negedge clk);
        fifo_wready = 0;
        #1 check(fifo_wvalid == 0, "R4 released", WW'(fifo_wvalid), 0);
    endtask

    initial begin
        logic [WW-1:0] a, b;
        for (int be = 0; be < 2; be++) begin
            do_reset(1'(be));
            for (int s = 0; s < 4; s++) begin
                a = 80'h0123_4567_89AB_CDEF_F00D ^ ({WW{1'b0}} | (WW'(s) * 80'h1111_0000_3333));
                rd_word(s, 1'(be), a);
                wr_word(s, ~a);
            end
        end
        // R9: back-to-back single-slice words
        do_reset(1'b0);
        a = 80'hAAAA_5555_AAAA_5555_0F0F;
        b = 80'h1234_0000_FFFF_8888_7777;
        @(negedge clk);
        fifo_rvalid = 1; fifo_rdata = a; rd_size = 0; rd_en = 0;
        @(negedge clk);
        fifo_rdata = b; rd_en = 1;
        #1;
        check(rd_data == a, "R9 first word", rd_data, a);
        check(fifo_rready == 1, "R9 refill on last", WW'(fifo_rready), 1);
        @(negedge clk);
        fifo_rvalid = 0;
        #1;
        check(rd_valid == 1, "R9 no bubble", WW'(rd_valid), 1);
        check(rd_data == b, "R9 second word", rd_data, b);
        @(negedge clk);
        rd_en = 0;
        #1 check(rd_valid == 0, "R9 drained", WW'(rd_valid), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule